// File: doc/BRIEF.md
# Byte-serial accumulator processor core

This block is a compact 8-bit processor core with two accumulators (A and B), a 16-bit index register X, a 16-bit program counter and a zero flag. It talks to one synchronous byte-wide memory over a 16-bit address bus. Each instruction is brought in one byte at a time: the core puts the program counter on the address bus, takes the returned byte into its instruction register and steps the program counter by one. The next byte is then fetched the same way. Once every byte of the instruction is in, an execute step runs. It forms the effective address, reads or writes memory if the instruction needs it, and updates the registers.

The instruction subset covers six ways of finding an operand. In inherent mode no operand is needed. In immediate mode the operand bytes sit in the instruction. Direct mode takes an 8-bit address on page zero. Extended mode takes a full 16-bit address. Indexed mode adds an unsigned offset to X. Relative mode gives a signed branch offset. The core stops on a stop instruction. On any opcode it does not know, it stops and raises a fault flag. It is meant to sit beside a small RAM that holds both program and data.

Top module: `acc_core`

## Requirements
- R1: While reset is held, the core drives address START_ADDR (default 0xC200), keeps write enable low, and shows halted=0 and fault=0. The first fetch after reset reads START_ADDR.
- R2: Each instruction byte costs two cycles. In the first cycle the program counter is on the address bus. In the second the returned byte is captured, and the address bus already shows the program counter plus one. Opcodes 0x1B and 0x3F are 1 byte long. Opcodes 0xCE, 0xB6, 0xBB, 0xB7 and 0xFE are 3 bytes long. The other opcodes in this list are 2 bytes long.
- R3: Extended opcodes 0xB6 (load A), 0xBB (add to A) and 0xB7 (store A) use the address made from byte 2 as the high half and byte 3 as the low half. The add wraps modulo 256.
- R4: Direct opcodes 0x96 (load A), 0x9B (add to A), 0x97 (store A) and 0xD6 (load B) use the address 0x00dd, where dd is byte 2.
- R5: Opcode 0x86 loads A from byte 2. Opcode 0xCE loads X from bytes 2 and 3, with byte 2 as the high half.
- R6: Opcode 0xA6 loads A from X plus the unsigned byte 2. The sum is taken over 16 bits, and X keeps its value.
- R7: Opcode 0xFE loads X from the extended address M and from M+1. M gives the high half and M+1 the low half. The two addresses are read in two consecutive address phases.
- R8: Opcode 0x1B adds B to A modulo 256 with no memory access. The next address on the bus is the next fetch.
- R9: Opcode 0x26 adds its sign-extended byte 2 to the address of the following instruction when Z=0. When Z=1 it falls through. Z is written only by 0x86, 0x96, 0xB6, 0xA6, 0xD6, 0x9B, 0xBB, 0x1B, 0xCE and 0xFE, and it is set when the 8-bit result (16-bit for X) is zero.
- R10: Opcode 0x3F sets halted=1 in the cycle after its execute cycle. Halted then stays 1, fault stays 0 and no write follows.
- R11: An opcode outside the listed set sets halted=1 and fault=1 in the cycle after its opcode byte is captured, and no write follows.
- R12: A store drives write enable for exactly one cycle, with the effective address on the bus and A on the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data (accumulator A) |
| mem_rdata | input | 8 | Read data, valid the cycle after its address |
| mem_we | output | 1 | Write enable |
| halted | output | 1 | Core has stopped |
| fault | output | 1 | Core stopped on an unknown opcode |

## Verification
Fetch addresses are due every second cycle, and the data address of a load or store is due in the cycle right after the last byte is captured. For 0xFE the second address comes one cycle later still. Halted appears one cycle after the stop instruction's execute cycle, or one cycle after an unknown opcode is captured. The bench runs a behavioural instruction model before each program and turns it into a cycle-by-cycle queue of expected bus values. It then compares every cycle from reset release, sampling one nanosecond after the falling edge. Register values that cannot be seen directly, such as a load into A or X, are brought out by later stores and checked against hand-worked values in memory.

// File: rtl/acc_pkg.sv
package acc_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] byte_t;

    typedef enum logic [2:0] {
        ST_FADDR, ST_FDATA, ST_EXEC, ST_MEM, ST_MEM2, ST_HALT
    } state_t;

    typedef enum logic [2:0] {
        M_INH, M_IMM, M_DIR, M_EXT, M_IDX, M_REL
    } mode_t;

    typedef enum logic [3:0] {
        OP_LDA, OP_LDB, OP_ADD, OP_STA, OP_LDX, OP_ABA, OP_BNE, OP_STOP, OP_BAD
    } op_t;

    typedef struct packed {
        op_t        op;
        mode_t      mode;
        logic [1:0] nbytes;
    } dec_t;

    localparam byte_t OPC_LDA_IMM = 8'h86;
    localparam byte_t OPC_LDA_DIR = 8'h96;
    localparam byte_t OPC_LDA_EXT = 8'hB6;
    localparam byte_t OPC_LDA_IDX = 8'hA6;
    localparam byte_t OPC_LDB_DIR = 8'hD6;
    localparam byte_t OPC_ADD_DIR = 8'h9B;
    localparam byte_t OPC_ADD_EXT = 8'hBB;
    localparam byte_t OPC_STA_DIR = 8'h97;
    localparam byte_t OPC_STA_EXT = 8'hB7;
    localparam byte_t OPC_LDX_IMM = 8'hCE;
    localparam byte_t OPC_LDX_EXT = 8'hFE;
    localparam byte_t OPC_ABA     = 8'h1B;
    localparam byte_t OPC_BNE     = 8'h26;
    localparam byte_t OPC_STOP    = 8'h3F;

    function automatic addr_t sext8(byte_t v);
        return {{(ADDR_W-DATA_W){v[DATA_W-1]}}, v};
    endfunction

    function automatic addr_t zext8(byte_t v);
        return {{(ADDR_W-DATA_W){1'b0}}, v};
    endfunction
endpackage

// File: rtl/acc_decode.sv
module acc_decode
    import acc_pkg::*;
(
    input  byte_t opcode,
    output dec_t  dec
);
    always_comb begin
        dec = '{op: OP_BAD, mode: M_INH, nbytes: 2'd1};
        case (opcode)
            OPC_LDA_IMM: dec = '{op: OP_LDA,  mode: M_IMM, nbytes: 2'd2};
            OPC_LDA_DIR: dec = '{op: OP_LDA,  mode: M_DIR, nbytes: 2'd2};
            OPC_LDA_EXT: dec = '{op: OP_LDA,  mode: M_EXT, nbytes: 2'd3};
            OPC_LDA_IDX: dec = '{op: OP_LDA,  mode: M_IDX, nbytes: 2'd2};
            OPC_LDB_DIR: dec = '{op: OP_LDB,  mode: M_DIR, nbytes: 2'd2};
            OPC_ADD_DIR: dec = '{op: OP_ADD,  mode: M_DIR, nbytes: 2'd2};
            OPC_ADD_EXT: dec = '{op: OP_ADD,  mode: M_EXT, nbytes: 2'd3};
            OPC_STA_DIR: dec = '{op: OP_STA,  mode: M_DIR, nbytes: 2'd2};
            OPC_STA_EXT: dec = '{op: OP_STA,  mode: M_EXT, nbytes: 2'd3};
            OPC_LDX_IMM: dec = '{op: OP_LDX,  mode: M_IMM, nbytes: 2'd3};
            OPC_LDX_EXT: dec = '{op: OP_LDX,  mode: M_EXT, nbytes: 2'd3};
            OPC_ABA:     dec = '{op: OP_ABA,  mode: M_INH, nbytes: 2'd1};
            OPC_BNE:     dec = '{op: OP_BNE,  mode: M_REL, nbytes: 2'd2};
            OPC_STOP:    dec = '{op: OP_STOP, mode: M_INH, nbytes: 2'd1};
            default:     dec = '{op: OP_BAD,  mode: M_INH, nbytes: 2'd1};
        endcase
    end
endmodule

// File: rtl/acc_addr.sv
module acc_addr
    import acc_pkg::*;
(
    input  mode_t mode,
    input  byte_t b1,
    input  byte_t b2,
    input  addr_t xr,
    input  addr_t pc,
    output addr_t ea
);
    always_comb begin
        case (mode)
            M_DIR:   ea = zext8(b1);
            M_EXT:   ea = {b1, b2};
            M_IDX:   ea = xr + zext8(b1);
            M_REL:   ea = pc + sext8(b1);
            default: ea = pc;
        endcase
    end
endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_pkg::*;
#(
    parameter logic [15:0] START_ADDR = 16'hC200
) (
    input  logic        clk,
    input  logic        rst,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    input  logic [7:0]  mem_rdata,
    output logic        mem_we,
    output logic        halted,
    output logic        fault
);
    state_t     st;
    addr_t      pc, xr, ea;
    byte_t      acc_a, acc_b, ir_op, ir_b1, ir_b2, dec_in, addend, sum;
    logic       zf, fault_q;
    logic [1:0] cnt;
    dec_t       dec;
    logic       mem_mode;

    assign dec_in = (st == ST_FDATA && cnt == 2'd0) ? mem_rdata : ir_op;

    acc_decode u_dec (.opcode(dec_in), .dec(dec));
    acc_addr   u_ea  (.mode(dec.mode), .b1(ir_b1), .b2(ir_b2), .xr(xr), .pc(pc), .ea(ea));

    assign mem_mode = (dec.mode == M_DIR) || (dec.mode == M_EXT) || (dec.mode == M_IDX);
    assign addend   = (st == ST_EXEC) ? acc_b : mem_rdata;
    assign sum      = acc_a + addend;

    always_comb begin
        mem_addr  = pc;
        mem_we    = 1'b0;
        mem_wdata = acc_a;
        if (st == ST_EXEC && mem_mode) begin
            mem_addr = ea;
            mem_we   = (dec.op == OP_STA);
        end else if (st == ST_MEM && dec.op == OP_LDX) begin
            mem_addr = ADDR_W'(ea + 16'd1);
        end
    end

    assign halted = (st == ST_HALT);
    assign fault  = fault_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_FADDR;
            pc      <= START_ADDR;
            xr      <= '0;
            acc_a   <= '0;
            acc_b   <= '0;
            ir_op   <= '0;
            ir_b1   <= '0;
            ir_b2   <= '0;
            zf      <= 1'b0;
            fault_q <= 1'b0;
            cnt     <= 2'd0;
        end else begin
            case (st)
                ST_FADDR: begin
                    pc <= ADDR_W'(pc + 16'd1);
                    st <= ST_FDATA;
                end
                ST_FDATA: begin
                    case (cnt)
                        2'd0:    ir_op <= mem_rdata;
                        2'd1:    ir_b1 <= mem_rdata;
                        default: ir_b2 <= mem_rdata;
                    endcase
                    if (cnt == 2'd0 && dec.op == OP_BAD) begin
                        fault_q <= 1'b1;
                        st      <= ST_HALT;
                    end else if (2'(cnt + 2'd1) == dec.nbytes) begin
                        cnt <= 2'd0;
                        st  <= ST_EXEC;
                    end else begin
                        cnt <= 2'(cnt + 2'd1);
                        st  <= ST_FADDR;
                    end
                end
                ST_EXEC: begin
                    st <= ST_FADDR;
                    case (dec.op)
                        OP_LDA: if (dec.mode == M_IMM) begin
                                    acc_a <= ir_b1;
                                    zf    <= (ir_b1 == '0);
                                end else st <= ST_MEM;
                        OP_LDX: if (dec.mode == M_IMM) begin
                                    xr <= {ir_b1, ir_b2};
                                    zf <= ({ir_b1, ir_b2} == '0);
                                end else st <= ST_MEM;
                        OP_LDB, OP_ADD: st <= ST_MEM;
                        OP_ABA: begin
                            acc_a <= sum;
                            zf    <= (sum == '0);
                        end
                        OP_BNE:  if (!zf) pc <= ea;
                        OP_STOP: st <= ST_HALT;
                        default: ;
                    endcase
                end
                ST_MEM: begin
                    st <= ST_FADDR;
                    case (dec.op)
                        OP_LDA: begin
                            acc_a <= mem_rdata;
                            zf    <= (mem_rdata == '0);
                        end
                        OP_LDB: begin
                            acc_b <= mem_rdata;
                            zf    <= (mem_rdata == '0);
                        end
                        OP_ADD: begin
                            acc_a <= sum;
                            zf    <= (sum == '0);
                        end
                        OP_LDX: begin
                            xr[15:8] <= mem_rdata;
                            st       <= ST_MEM2;
                        end
                        default: ;
                    endcase
                end
                ST_MEM2: begin
                    xr[7:0] <= mem_rdata;
                    zf      <= ({xr[15:8], mem_rdata} == '0);
                    st      <= ST_FADDR;
                end
                default: st <= ST_HALT;
            endcase
        end
    end

    AST_FETCH_STEP: assert property (@(posedge clk) disable iff (rst)
        (st == ST_FADDR) |=> (mem_addr == 16'($past(mem_addr) + 16'd1))); // R2
    AST_DIRECT_PAGE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (st == ST_EXEC && dec.mode == M_DIR) |-> (mem_addr[15:8] == 8'h00)); // R4
    AST_INDEX_KEPT: assert property (@(posedge clk) disable iff (rst)
        (st == ST_EXEC && dec.mode == M_IDX) |=> (xr == $past(xr))); // R6
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && !mem_we)); // R10
    AST_FAULT_HALTS: assert property (@(posedge clk) disable iff (rst)
        fault |-> halted); // R11
    AST_STORE_PULSE: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we); // R12
endmodule

// File: tb/sim_acc_core.sv
`timescale 1ns/1ps
module sim_acc_core;
    localparam logic [15:0] START = 16'hC200;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic        mem_we, halted, fault;

    acc_core #(.START_ADDR(START)) u0 (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_we(mem_we), .halted(halted), .fault(fault)
    );

    always #2 clk = ~clk;

    logic [7:0] mem  [logic [15:0]];
    logic [7:0] rmem [logic [15:0]];

    function automatic logic [7:0] mrd(logic [15:0] a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction
    function automatic logic [7:0] rrd(logic [15:0] a);
        return rmem.exists(a) ? rmem[a] : 8'h00;
    endfunction

    always @(posedge clk) begin
        logic [7:0] t;
        t = mrd(mem_addr);
        if (mem_we) mem[mem_addr] = mem_wdata;
        mem_rdata <= t;
    end

    bit          q_chk [$];
    logic [15:0] q_addr[$];
    bit          q_we  [$];
    logic [7:0]  q_wd  [$];
    bit          q_h   [$];
    bit          q_f   [$];
    string       q_tag [$];

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic push(input bit c, input logic [15:0] ad, input bit w,
                        input logic [7:0] d, input bit h, input bit f, input string t);
        q_chk.push_back(c); q_addr.push_back(ad); q_we.push_back(w);
        q_wd.push_back(d); q_h.push_back(h); q_f.push_back(f); q_tag.push_back(t);
    endtask

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic poke(input logic [15:0] a, input logic [7:0] v);
        mem[a] = v;
        rmem[a] = v;
    endtask

    function automatic bit known(logic [7:0] op);
        case (op)
            8'h86, 8'hCE, 8'h96, 8'h9B, 8'h97, 8'hD6, 8'hB6, 8'hBB,
            8'hB7, 8'hFE, 8'hA6, 8'h1B, 8'h3F, 8'h26: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // Behavioural instruction model producing the expected bus trace (R2 fetch timing)
    task automatic fetch_ref(inout logic [15:0] pc, output logic [7:0] v);
        v = rrd(pc);
        push(1, pc, 0, 8'h00, 0, 0, "R2");
        push(0, 16'h0, 0, 8'h00, 0, 0, "R2");
        pc = pc + 16'd1;
    endtask

    task automatic ref_run();
        logic [15:0] pc, x, ea;
        logic [7:0]  a, b, op, b1, b2, d;
        bit z, done;
        int len, steps;
        string tg;
        pc = START; x = 0; a = 0; b = 0; z = 0; done = 0; steps = 0;
        b1 = 0; b2 = 0;
        while (!done && steps < 2000) begin
            steps++;
            fetch_ref(pc, op);
            if (!known(op)) begin
                // R11: halted and fault in the cycle after the opcode byte
                for (int i = 0; i < 5; i++) push(0, 16'h0, 0, 8'h00, 1, 1, "R11");
                done = 1;
            end else begin
                len = (op == 8'h1B || op == 8'h3F) ? 1 :
                      (op == 8'hCE || op == 8'hB6 || op == 8'hBB || op == 8'hB7 || op == 8'hFE) ? 3 : 2;
                if (len > 1) fetch_ref(pc, b1);
                if (len > 2) fetch_ref(pc, b2);
                case (op)
                    8'h96, 8'h9B, 8'h97, 8'hD6: begin ea = {8'h00, b1}; tg = "R4"; end
                    8'hA6:                      begin ea = x + {8'h00, b1}; tg = "R6"; end
                    8'hFE:                      begin ea = {b1, b2}; tg = "R7"; end
                    default:                    begin ea = {b1, b2}; tg = "R3"; end
                endcase
                case (op)
                    8'h86: begin a = b1; z = (a == 0); push(0, 0, 0, 0, 0, 0, "R5"); end
                    8'hCE: begin x = {b1, b2}; z = (x == 0); push(0, 0, 0, 0, 0, 0, "R5"); end
                    8'h1B: begin a = a + b; z = (a == 0); push(0, 0, 0, 0, 0, 0, "R8"); end
                    8'h26: begin
                        if (!z) pc = pc + {{8{b1[7]}}, b1};
                        push(0, 0, 0, 0, 0, 0, "R9");
                    end
                    8'h3F: begin
                        push(0, 0, 0, 0, 0, 0, "R10");
                        for (int i = 0; i < 5; i++) push(0, 16'h0, 0, 8'h00, 1, 0, "R10");
                        done = 1;
                    end
                    8'h97, 8'hB7: begin
                        push(1, ea, 1, a, 0, 0, "R12");
                        rmem[ea] = a;
                    end
                    8'hFE: begin
                        push(1, ea, 0, 0, 0, 0, "R7");
                        push(1, ea + 16'd1, 0, 0, 0, 0, "R7");
                        push(0, 0, 0, 0, 0, 0, "R7");
                        x = {rrd(ea), rrd(ea + 16'd1)};
                        z = (x == 0);
                    end
                    default: begin
                        push(1, ea, 0, 0, 0, 0, tg);
                        push(0, 0, 0, 0, 0, 0, tg);
                        d = rrd(ea);
                        case (op)
                            8'hD6:        b = d;
                            8'h9B, 8'hBB: a = a + d;
                            default:      a = d;
                        endcase
                        z = ((op == 8'hD6) ? b : a) == 0;
                    end
                endcase
            end
        end
    endtask

    task automatic run_prog();
        bit ok;
        q_chk.delete(); q_addr.delete(); q_we.delete(); q_wd.delete();
        q_h.delete(); q_f.delete(); q_tag.delete();
        ref_run();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state at the ports
        check(mem_addr === START && mem_we === 1'b0 && halted === 1'b0 && fault === 1'b0,
              "R1", "reset addr/we/halted/fault",
              {mem_addr, 5'b0, mem_we, halted, fault}, {START, 8'h00});
        @(negedge clk);
        rst = 1'b0;
        #1;
        while (q_chk.size() > 0) begin
            bit c, w, h, f;
            logic [15:0] ad;
            logic [7:0] wd;
            string t;
            c = q_chk.pop_front(); ad = q_addr.pop_front(); w = q_we.pop_front();
            wd = q_wd.pop_front(); h = q_h.pop_front(); f = q_f.pop_front(); t = q_tag.pop_front();
            ok = (mem_we === w) && (!w || mem_wdata === wd) && (!c || mem_addr === ad) &&
                 (halted === h) && (fault === f);
            check(ok, t, "addr,wdata,we,halted,fault",
                  {c ? mem_addr : 16'h0, w ? mem_wdata : 8'h00, 5'b0, mem_we, halted, fault},
                  {c ? ad : 16'h0, w ? wd : 8'h00, 5'b0, w, h, f});
            @(negedge clk);
            #1;
        end
    endtask

    initial begin
        // Program 1: every addressing mode, a counted loop and both branch outcomes
        poke(16'h0020, 8'h07); poke(16'h0030, 8'h03); poke(16'h0031, 8'hFF);
        poke(16'hC301, 8'h90); poke(16'hC311, 8'h3C); poke(16'hC320, 8'h12);
        poke(16'hC321, 8'h34); poke(16'hC400, 8'h5A); poke(16'h1236, 8'h77);
        poke(16'hC200, 8'h86); poke(16'hC201, 8'h05);                          // LDAA #05   R5
        poke(16'hC202, 8'hD6); poke(16'hC203, 8'h20);                          // LDAB $20   R4
        poke(16'hC204, 8'h1B);                                                 // ABA        R8
        poke(16'hC205, 8'hB7); poke(16'hC206, 8'hC3); poke(16'hC207, 8'h00);   // STAA $C300 R12
        poke(16'hC208, 8'hCE); poke(16'hC209, 8'hC3); poke(16'hC20A, 8'h10);   // LDX #C310
        poke(16'hC20B, 8'hA6); poke(16'hC20C, 8'hF0);                          // LDAA F0,X  R6
        poke(16'hC20D, 8'h97); poke(16'hC20E, 8'h21);
        poke(16'hC20F, 8'hA6); poke(16'hC210, 8'h01);                          // LDAA 1,X
        poke(16'hC211, 8'h97); poke(16'hC212, 8'h22);
        poke(16'hC213, 8'hFE); poke(16'hC214, 8'hC3); poke(16'hC215, 8'h20);   // LDX $C320  R7
        poke(16'hC216, 8'hA6); poke(16'hC217, 8'h02);
        poke(16'hC218, 8'hBB); poke(16'hC219, 8'hC3); poke(16'hC21A, 8'h01);   // ADDA $C301 R3
        poke(16'hC21B, 8'hB7); poke(16'hC21C, 8'hC3); poke(16'hC21D, 8'h02);
        poke(16'hC21E, 8'h96); poke(16'hC21F, 8'h30);
        poke(16'hC220, 8'h9B); poke(16'hC221, 8'h31);
        poke(16'hC222, 8'h26); poke(16'hC223, 8'hFC);                          // BNE back   R9
        poke(16'hC224, 8'h26); poke(16'hC225, 8'h02);                          // not taken
        poke(16'hC226, 8'h97); poke(16'hC227, 8'h32);
        poke(16'hC228, 8'h86); poke(16'hC229, 8'h01);
        poke(16'hC22A, 8'h26); poke(16'hC22B, 8'h01);                          // taken forward
        poke(16'hC22C, 8'h00);
        poke(16'hC22D, 8'h97); poke(16'hC22E, 8'h33);
        poke(16'hC22F, 8'h3F);                                                 // STOP       R10
        run_prog();
        check(mrd(16'hC300) == 8'h0C, "R8",  "ABA result", mrd(16'hC300), 8'h0C);
        check(mrd(16'h0021) == 8'h5A, "R6",  "indexed page cross", mrd(16'h0021), 8'h5A);
        check(mrd(16'h0022) == 8'h3C, "R6",  "X kept after indexed", mrd(16'h0022), 8'h3C);
        check(mrd(16'hC302) == 8'h07, "R3",  "extended add wrap", mrd(16'hC302), 8'h07);
        check(mrd(16'h0032) == 8'h00, "R9",  "loop end value", mrd(16'h0032), 8'h00);
        check(mrd(16'h0033) == 8'h01, "R9",  "forward branch skip", mrd(16'h0033), 8'h01);
        check(halted === 1'b1 && fault === 1'b0, "R10", "stopped state",
              {halted, fault}, 2'b10);

        // Program 2: unknown opcode after a valid instruction
        mem.delete(); rmem.delete();
        poke(16'hC200, 8'h86); poke(16'hC201, 8'hAA);
        poke(16'hC202, 8'h01);
        poke(16'hC203, 8'h97); poke(16'hC204, 8'h40);
        run_prog();
        check(!mem.exists(16'h0040), "R11", "no store after fault",
              mrd(16'h0040), 8'h00);
        check(halted === 1'b1 && fault === 1'b1, "R11", "fault state",
              {halted, fault}, 2'b11);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule